// File: doc/BRIEF.md
# Dual-Mode Serial Character Receiver

This block takes one serial receive line and turns it into parallel characters. It works in two modes, picked by a mode input. In asynchronous mode it uses a tick that runs at a multiple of the bit rate (16 by default). It finds the start bit, confirms it at the middle of the start bit, and samples every later bit at its centre. In synchronous mode it samples the line once on each rising edge of a bit clock supplied from outside. A low level seen while idle counts as a start bit at once. Both modes share one framing path: data bits arrive least significant first, then an optional parity bit, then one stop bit.

Each finished character goes into a holding register, and a ready flag is set. The block also keeps a sticky overrun flag and a sticky parity error flag, and drives an interrupt line that can be masked. The processor side has three controls: a strobe that marks the holding register as read, a strobe that clears the error flags, and an interrupt enable. The receive line and the external bit clock both pass through a two-stage synchronizer before any logic uses them.

Top module: `serial_char_rx`

## Requirements
- R1: A synchronous active-low reset puts the receiver in idle and clears the ready flag, the overrun flag, the parity error flag and the interrupt output.
- R2: In asynchronous mode (mode input 0), a low line seen on a tick starts a start-bit check. On the 8th tick, counting the detecting tick as the first, a high line makes the receiver return to idle and no character is produced.
- R3: In asynchronous mode, once the start bit is confirmed, the line is sampled every 16 ticks. The order is DATA_BITS data bits least significant first, then the parity bit if parity is enabled, then one stop bit.
- R4: In synchronous mode (mode input 1), the line is sampled once on each rising edge of the external bit clock. A low sample while idle is taken as the start bit with no confirmation.
- R5: When the stop bit is sampled, the assembled data is written to the holding register and the ready flag is set.
- R6: The interrupt output is high exactly while the ready flag is set and the interrupt enable is high.
- R7: If a character finishes while the ready flag is set and no read strobe arrives in the same cycle, the overrun flag is set. The holding register then holds the newest character.
- R8: A read strobe clears the ready flag. It leaves the overrun and parity error flags unchanged.
- R9: The status-clear strobe clears the overrun and parity error flags. A new error in the same cycle wins. Until that strobe, both flags stay set.
- R10: With parity enabled, parity select 0 means even parity: data plus parity bit hold an even number of ones. Parity select 1 means odd parity. A mismatch sets the parity error flag, and the character is still stored and flagged ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate (asynchronous mode) |
| baud_clk | input | 1 | External bit clock (synchronous mode) |
| sync_mode | input | 1 | 0 asynchronous, 1 synchronous |
| parity_en | input | 1 | 1 = a parity bit follows the data |
| parity_odd | input | 1 | 0 even parity, 1 odd parity |
| hold_rd | input | 1 | Strobe: holding register has been read |
| clr_status | input | 1 | Strobe: clear overrun and parity error flags |
| irq_en | input | 1 | Interrupt enable for the ready flag |
| rx_char | output | DATA_BITS | Holding register contents |
| rx_ready | output | 1 | Character waiting in holding register |
| overrun | output | 1 | Sticky overrun flag |
| parity_err | output | 1 | Sticky parity error flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: 8 data bits and 16 ticks per bit. At that size every one of the 256 character codes can be sent in both modes, with parity cycling through none, even and odd, and each received value is compared with the sent one. The small bit period also keeps directed runs short. These cover a start pulse too short to confirm, a synchronous start with no confirmation, wrong parity, overrun with overwrite, and the priority between the read and status-clear strobes and the flags.

// File: rtl/rx_pkg.sv
// Shared state encodings for the serial character receiver.
package rx_pkg;
    typedef enum logic [1:0] {TS_IDLE, TS_CONF, TS_RUN} tstate_t;
    typedef enum logic [1:0] {FS_IDLE, FS_DATA, FS_PAR, FS_STOP} fstate_t;
endpackage

// File: rtl/rx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes each bit is independent; RST_VAL gives the idle level per bit.
module rx_sync #(
    parameter int WIDTH = 2,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first capture stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d;
            end
        end else begin : g_next
            // later settling stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rx_timing.sv
// Bit timing: finds start bits and produces one strobe at the centre of
// each later bit. Asynchronous mode counts OVS ticks per bit and confirms
// the start bit on tick OVS/2. Synchronous mode strobes on every rising
// edge of the synchronized bit clock. Assumes inputs are synchronized and
// that the mode does not change during a frame.
module rx_timing
    import rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic tick,
    input  logic rxd_s,
    input  logic bclk_s,
    input  logic last_bit,
    output logic start_go,
    output logic bit_strobe
);
    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] CONF_AT  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVS - 1);

    tstate_t          st;
    logic [CNT_W-1:0] cnt;
    logic             bclk_d;
    logic             bclk_rise;

    // delayed copy of bit clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_s;
    end

    assign bclk_rise = bclk_s & ~bclk_d;

    // start acceptance and bit-centre strobe
    always_comb begin
        if (sync_mode)
            start_go = (st == TS_IDLE) && bclk_rise && !rxd_s;
        else
            start_go = (st == TS_CONF) && tick && (cnt == CONF_AT) && !rxd_s;
        bit_strobe = (st == TS_RUN) &&
                     (sync_mode ? bclk_rise : (tick && cnt == LAST_CNT));
    end

    // timing state and tick counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= TS_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                TS_IDLE: begin
                    if (sync_mode) begin
                        if (start_go) st <= TS_RUN;
                    end else if (tick && !rxd_s) begin
                        st  <= TS_CONF;
                        cnt <= CNT_W'(1);
                    end
                end
                TS_CONF: begin
                    if (tick) begin
                        if (cnt == CONF_AT) begin
                            st  <= rxd_s ? TS_IDLE : TS_RUN;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                TS_RUN: begin
                    if (!sync_mode && tick)
                        cnt <= (cnt == LAST_CNT) ? '0 : cnt + 1'b1;
                    if (bit_strobe && last_bit)
                        st <= TS_IDLE;
                end
                default: st <= TS_IDLE;
            endcase
        end
    end

    // R2: a start that reads high at the check point is abandoned
    a_r2_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && st == TS_CONF && tick && cnt == CONF_AT && rxd_s)
        |=> (st == TS_IDLE));
    // R3: asynchronous bit sampling happens only on a tick
    a_r3_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && bit_strobe) |-> tick);
    // R4: synchronous sampling happens only on a bit clock rise
    a_r4_strobe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && bit_strobe) |-> $rose(bclk_s));
endmodule

// File: rtl/rx_frame.sv
// Frame assembly: shifts in DATA_BITS data bits least significant first,
// takes an optional parity bit, then completes on the stop bit with a
// one-cycle done pulse, the data and the parity check result.
// Assumes one strobe per bit from the timing unit; DATA_BITS >= 2.
module rx_frame
    import rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_go,
    input  logic                 bit_strobe,
    input  logic                 rxd_s,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    output logic                 last_bit,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 perr
);
    localparam int IDX_W = $clog2(DATA_BITS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    fstate_t              st;
    logic [IDX_W-1:0]     idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_bit;

    assign last_bit = (st == FS_STOP);

    // frame sequencing, shifting and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= FS_IDLE;
            idx     <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            done    <= 1'b0;
            data    <= '0;
            perr    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                FS_IDLE: begin
                    if (start_go) begin
                        st  <= FS_DATA;
                        idx <= '0;
                    end
                end
                FS_DATA: begin
                    if (bit_strobe) begin
                        shreg <= {rxd_s, shreg[DATA_BITS-1:1]};
                        if (idx == LAST_IDX) st <= parity_en ? FS_PAR : FS_STOP;
                        else                 idx <= idx + 1'b1;
                    end
                end
                FS_PAR: begin
                    if (bit_strobe) begin
                        par_bit <= rxd_s;
                        st      <= FS_STOP;
                    end
                end
                FS_STOP: begin
                    if (bit_strobe) begin
                        done <= 1'b1;
                        data <= shreg;
                        perr <= parity_en & (^shreg ^ par_bit ^ parity_odd);
                        st   <= FS_IDLE;
                    end
                end
                default: st <= FS_IDLE;
            endcase
        end
    end

    // R5: a stop-bit sample always yields a completion pulse
    a_r5_stop_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FS_STOP && bit_strobe) |=> done);
    // R3: with parity off the data phase goes straight to the stop bit
    a_r3_no_parity_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FS_DATA && bit_strobe && idx == LAST_IDX && !parity_en)
        |=> (st == FS_STOP));
endmodule

// File: rtl/rx_status.sv
// Holding register and status flags: ready, sticky overrun, sticky parity
// error, and the masked interrupt. Assumes done is a one-cycle pulse.
module rx_status #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] data,
    input  logic                 frame_perr,
    input  logic                 hold_rd,
    input  logic                 clr_status,
    input  logic                 irq_en,
    output logic [DATA_BITS-1:0] rx_char,
    output logic                 rx_ready,
    output logic                 overrun,
    output logic                 parity_err,
    output logic                 irq
);
    // holding register and flag updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_char    <= '0;
            rx_ready   <= 1'b0;
            overrun    <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            if (done) rx_char <= data;

            if (done)         rx_ready <= 1'b1;
            else if (hold_rd) rx_ready <= 1'b0;

            if (done && rx_ready && !hold_rd) overrun <= 1'b1;
            else if (clr_status)              overrun <= 1'b0;

            if (done && frame_perr) parity_err <= 1'b1;
            else if (clr_status)    parity_err <= 1'b0;
        end
    end

    // masked interrupt request
    assign irq = rx_ready & irq_en;

    // R5: completion sets ready
    a_r5_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_ready);
    // R7: completion onto an unread character flags overrun
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_ready && !hold_rd) |=> overrun);
    // R8: a read with no new character clears ready
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_rd && !done) |=> !rx_ready);
    // R9: overrun stays set until the status-clear strobe
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !clr_status) |=> overrun);
    // R9: status-clear without a new event drops both error flags
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !done) |=> (!overrun && !parity_err));
endmodule

// File: rtl/serial_char_rx.sv
// Dual-mode serial character receiver top. Synchronizes the line and the
// external bit clock, then chains timing, frame assembly and status.
// Assumes baud_tick is a one-cycle pulse at OVS times the bit rate and
// that the external bit clock is much slower than clk.
module serial_char_rx #(
    parameter int DATA_BITS = 8,
    parameter int OVS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rxd,
    input  logic                 baud_tick,
    input  logic                 baud_clk,
    input  logic                 sync_mode,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic                 hold_rd,
    input  logic                 clr_status,
    input  logic                 irq_en,
    output logic [DATA_BITS-1:0] rx_char,
    output logic                 rx_ready,
    output logic                 overrun,
    output logic                 parity_err,
    output logic                 irq
);
    logic [1:0]           sync_q;
    logic                 rxd_s;
    logic                 bclk_s;
    logic                 start_go;
    logic                 bit_strobe;
    logic                 last_bit;
    logic                 done;
    logic [DATA_BITS-1:0] data;
    logic                 frame_perr;

    rx_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({baud_clk, rxd}),
        .q     (sync_q)
    );

    assign rxd_s  = sync_q[0];
    assign bclk_s = sync_q[1];

    rx_timing #(.OVS(OVS)) u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_mode  (sync_mode),
        .tick       (baud_tick),
        .rxd_s      (rxd_s),
        .bclk_s     (bclk_s),
        .last_bit   (last_bit),
        .start_go   (start_go),
        .bit_strobe (bit_strobe)
    );

    rx_frame #(.DATA_BITS(DATA_BITS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_go   (start_go),
        .bit_strobe (bit_strobe),
        .rxd_s      (rxd_s),
        .parity_en  (parity_en),
        .parity_odd (parity_odd),
        .last_bit   (last_bit),
        .done       (done),
        .data       (data),
        .perr       (frame_perr)
    );

    rx_status #(.DATA_BITS(DATA_BITS)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .data       (data),
        .frame_perr (frame_perr),
        .hold_rd    (hold_rd),
        .clr_status (clr_status),
        .irq_en     (irq_en),
        .rx_char    (rx_char),
        .rx_ready   (rx_ready),
        .overrun    (overrun),
        .parity_err (parity_err),
        .irq        (irq)
    );

    // R1: right after reset no flag is set
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!rx_ready && !overrun && !parity_err));
endmodule

// File: tb/tb_serial_char_rx.sv
// Self-checking bench: sweeps all character codes in both modes, then
// runs directed cases for start rejection, parity, overrun and strobes.
module tb_serial_char_rx;
    localparam int DB  = 8;
    localparam int OVS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic          baud_tick = 1'b0;
    logic          baud_clk = 1'b0;
    logic [2:0]    bdiv = '0;
    logic          sync_mode = 1'b0;
    logic          parity_en = 1'b0;
    logic          parity_odd = 1'b0;
    logic          hold_rd = 1'b0;
    logic          clr_status = 1'b0;
    logic          irq_en = 1'b1;
    logic [DB-1:0] rx_char;
    logic          rx_ready, overrun, parity_err, irq;
    int            nchk = 0;
    int            nerr = 0;

    serial_char_rx #(.DATA_BITS(DB), .OVS(OVS)) dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .baud_tick(baud_tick),
        .baud_clk(baud_clk), .sync_mode(sync_mode), .parity_en(parity_en),
        .parity_odd(parity_odd), .hold_rd(hold_rd), .clr_status(clr_status),
        .irq_en(irq_en), .rx_char(rx_char), .rx_ready(rx_ready),
        .overrun(overrun), .parity_err(parity_err), .irq(irq)
    );

    always #10 clk = ~clk;

    // tick every other cycle, bit clock period of 8 cycles
    always @(negedge clk) begin
        baud_tick <= ~baud_tick;
        bdiv      <= bdiv + 3'd1;
        baud_clk  <= bdiv[2];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic par_of(input logic [DB-1:0] v, input logic odd, input logic flip);
        return (^v) ^ odd ^ flip;
    endfunction

    task automatic async_bit(input logic b);
        rxd = b;
        repeat (2 * OVS) @(negedge clk);
    endtask

    task automatic send_async(input logic [DB-1:0] v, input logic flip);
        async_bit(1'b0);
        for (int i = 0; i < DB; i++) async_bit(v[i]);
        if (parity_en) async_bit(par_of(v, parity_odd, flip));
        async_bit(1'b1);
        repeat (8) @(negedge clk);
    endtask

    task automatic sync_bit(input logic b);
        @(negedge baud_clk);
        rxd = b;
    endtask

    task automatic send_sync(input logic [DB-1:0] v, input logic flip);
        sync_bit(1'b0);
        for (int i = 0; i < DB; i++) sync_bit(v[i]);
        if (parity_en) sync_bit(par_of(v, parity_odd, flip));
        sync_bit(1'b1);
        @(negedge baud_clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_rd;
        @(negedge clk) hold_rd = 1'b1;
        @(negedge clk) hold_rd = 1'b0;
    endtask

    task automatic pulse_clr;
        @(negedge clk) clr_status = 1'b1;
        @(negedge clk) clr_status = 1'b0;
    endtask

    task automatic set_par(input int m);
        parity_en  = (m != 0);
        parity_odd = (m == 2);
    endtask

    task automatic sweep(input logic mode);
        sync_mode = mode;
        for (int v = 0; v < 256; v++) begin
            set_par(v % 3);
            if (mode) send_sync(DB'(v), 1'b0);
            else      send_async(DB'(v), 1'b0);
            chk(mode ? "R4 data" : "R3 data", 32'(rx_char), 32'(v));
            chk("R5 ready", 32'(rx_ready), 32'd1);
            chk("R10 no parity error", 32'(parity_err), 32'd0);
            chk("R7 no overrun", 32'(overrun), 32'd0);
            pulse_rd();
            chk("R8 read clears ready", 32'(rx_ready), 32'd0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 ready", 32'(rx_ready), 32'd0);
        chk("R1 overrun", 32'(overrun), 32'd0);
        chk("R1 parity", 32'(parity_err), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        sweep(1'b0);
        sweep(1'b1);

        // R2: start too short to confirm yields nothing
        sync_mode = 1'b0;
        set_par(0);
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (80) @(negedge clk);
        chk("R2 short start rejected", 32'(rx_ready), 32'd0);
        send_async(8'h5A, 1'b0);
        chk("R2 next char after reject", 32'(rx_char), 32'h5A);
        pulse_rd();

        // R4: synchronous start taken with no confirmation
        sync_mode = 1'b1;
        sync_bit(1'b0);
        sync_bit(1'b1);
        repeat (11) @(negedge baud_clk);
        repeat (6) @(negedge clk);
        chk("R4 unconfirmed start", 32'(rx_ready), 32'd1);
        chk("R4 all-ones char", 32'(rx_char), 32'hFF);
        pulse_rd();

        // R10: wrong even and odd parity flagged, char still stored
        set_par(1);
        send_sync(8'h3C, 1'b1);
        chk("R10 even mismatch", 32'(parity_err), 32'd1);
        chk("R10 char stored", 32'(rx_char), 32'h3C);
        chk("R10 ready", 32'(rx_ready), 32'd1);
        pulse_rd();
        chk("R8 read keeps parity err", 32'(parity_err), 32'd1);
        pulse_clr();
        chk("R9 clear parity err", 32'(parity_err), 32'd0);
        sync_mode = 1'b0;
        set_par(2);
        send_async(8'h81, 1'b1);
        chk("R10 odd mismatch", 32'(parity_err), 32'd1);
        pulse_rd();
        pulse_clr();

        // R7, R6: overrun and interrupt masking
        set_par(0);
        send_async(8'h11, 1'b0);
        chk("R6 irq enabled", 32'(irq), 32'd1);
        irq_en = 1'b0;
        #1;
        chk("R6 irq masked", 32'(irq), 32'd0);
        irq_en = 1'b1;
        send_async(8'h22, 1'b0);
        chk("R7 overrun set", 32'(overrun), 32'd1);
        chk("R7 newest char kept", 32'(rx_char), 32'h22);
        pulse_rd();
        chk("R8 ready cleared", 32'(rx_ready), 32'd0);
        chk("R6 irq follows ready", 32'(irq), 32'd0);
        chk("R9 overrun sticky after read", 32'(overrun), 32'd1);
        repeat (50) @(negedge clk);
        chk("R9 overrun still sticky", 32'(overrun), 32'd1);
        pulse_clr();
        chk("R9 overrun cleared", 32'(overrun), 32'd0);

        // R1: reset mid-state clears flags
        send_async(8'h77, 1'b0);
        send_async(8'h66, 1'b0);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R1 reset clears ready", 32'(rx_ready), 32'd0);
        chk("R1 reset clears overrun", 32'(overrun), 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule